// File: doc/BRIEF.md
# Subtractive Greatest Common Divisor Engine

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. At each step the larger of the two working values is replaced by the difference between them. When the two values match, that value is the answer. Two parts make up the block. The datapath holds the two working registers, a three-way magnitude comparator, two select multiplexers in front of a single shared subtractor, and a write-back select that loads each register from either the external operand or the subtractor output. A separate finite-state controller sees only the comparator status. It drives only the load enables, the multiplexer selects and the completion flag.

To use the block, a caller presents both operands and pulses `start` while the engine is idle or finished. When `done` rises, `result` holds the answer. Both stay unchanged until the next accepted `start`. A zero operand ends the run at once, so the engine can never loop forever.

Top module: `gcd_core`

## Requirements
- R1: While reset is held, and after it is released with no start, `done` is 0 and `result` is 0.
- R2: A `start` sampled high while idle or finished loads both operands on the next edge, and `done` reads 0 after that first edge.
- R3: Each subtract step writes exactly one working register: A becomes A−B only when A>B, and B becomes B−A only when B>A. Every step uses the same single subtractor, and the written register strictly decreases.
- R4: When `done` rises, `result` equals the greatest common divisor of the loaded operands. This happens exactly 3+2n clock edges after the edge that sampled `start`, where n is the number of subtractions.
- R5: Equal operands finish after 3 edges, with `result` equal to that operand. This includes the all-ones value of the default width.
- R6: With B zero, the run finishes after 3 edges with `result` equal to A (zero when both are zero). With A zero and B nonzero, it finishes after 4 edges with `result` equal to B.
- R7: While `start` is low, `done` stays 1 and `result` stays constant once finished. Changes on the operand inputs are ignored.
- R8: A `start` raised while a computation is in progress is ignored. The result and the latency are those of the running operands.
- R9: The operand width is the parameter `W`, 16 by default, and `result` has that width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted when idle or finished) |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| result | output | W | Computed divisor, valid while done is high |
| done | output | 1 | Computation finished |

## Verification
Counting from the edge that samples `start`, the bench expects `done` low after edge 1. It expects `done` high with the final `result` after edge 3+2n, where n comes from an independent model of the subtraction sequence. The A-zero case adds one edge for the copy step. The bench counts edges one by one and samples on the falling edge after each one. It records the first edge at which `done` is seen, so early or late completion fails just as a wrong value does. Holding behaviour is sampled several edges after completion, both with operand changes on the inputs and with a start pulse injected mid-run.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_CMP  = 3'd2,
        ST_SUBA = 3'd3,
        ST_SUBB = 3'd4,
        ST_COPY = 3'd5,
        ST_DONE = 3'd6
    } gcd_state_t;

    // Datapath control word driven by the controller
    typedef struct packed {
        logic ld_a;
        logic ld_b;
        logic sel_min;   // 0: minuend A, 1: minuend B
        logic sel_sub;   // 0: subtrahend B, 1: subtrahend A
        logic sel_src;   // 0: external operand, 1: subtractor output
        logic done;
    } gcd_ctl_t;

    // Comparator status returned to the controller
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic a_zero;
        logic b_zero;
    } gcd_sts_t;

endpackage

// File: rtl/gcd_cmp.sv
module gcd_cmp
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output gcd_sts_t     sts
);

    always_comb begin
        sts        = '0;
        sts.eq     = (a == b);
        sts.gt     = (a > b);
        sts.lt     = (a < b);
        sts.a_zero = (a == '0);
        sts.b_zero = (b == '0);
    end

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  gcd_ctl_t     ctl,
    output gcd_sts_t     sts,
    output logic [W-1:0] a_val
);

    localparam int NREG = 2;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] r;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;

    logic [W-1:0]            minuend;
    logic [W-1:0]            subtrahend;
    logic [W-1:0]            diff;
    logic [NREG-1:0][W-1:0]  ext;
    logic [NREG-1:0]         ld;

    // Operand select muxes feeding the single shared subtractor
    assign minuend    = ctl.sel_min ? dp_q.r[1] : dp_q.r[0];
    assign subtrahend = ctl.sel_sub ? dp_q.r[0] : dp_q.r[1];
    assign diff       = minuend - subtrahend;

    assign ext[0] = op_a;
    assign ext[1] = op_b;
    assign ld[0]  = ctl.ld_a;
    assign ld[1]  = ctl.ld_b;

    always_comb begin
        dp_d = dp_q;
        for (int i = 0; i < NREG; i++) begin
            if (ld[i]) begin
                dp_d.r[i] = ctl.sel_src ? diff : ext[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    gcd_cmp #(.W(W)) u_cmp (
        .a   (dp_q.r[0]),
        .b   (dp_q.r[1]),
        .sts (sts)
    );

    assign a_val = dp_q.r[0];

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  gcd_sts_t   sts,
    output gcd_ctl_t   ctl,
    output gcd_state_t state
);

    typedef struct packed {
        gcd_state_t st;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;

    // Next-state logic
    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ST_IDLE: if (start) ctrl_d.st = ST_LOAD;
            ST_LOAD: ctrl_d.st = ST_CMP;
            ST_CMP: begin
                if (sts.eq || sts.b_zero) ctrl_d.st = ST_DONE;
                else if (sts.a_zero)      ctrl_d.st = ST_COPY;
                else if (sts.gt)          ctrl_d.st = ST_SUBA;
                else                      ctrl_d.st = ST_SUBB;
            end
            ST_SUBA: ctrl_d.st = ST_CMP;
            ST_SUBB: ctrl_d.st = ST_CMP;
            ST_COPY: ctrl_d.st = ST_DONE;
            ST_DONE: if (start) ctrl_d.st = ST_LOAD;
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    // Moore decode of the datapath control word
    always_comb begin
        ctl = '0;
        unique case (ctrl_q.st)
            ST_LOAD: begin
                ctl.ld_a    = 1'b1;
                ctl.ld_b    = 1'b1;
                ctl.sel_src = 1'b0;
            end
            ST_SUBA: begin
                ctl.ld_a    = 1'b1;
                ctl.sel_min = 1'b0;
                ctl.sel_sub = 1'b0;
                ctl.sel_src = 1'b1;
            end
            ST_SUBB: begin
                ctl.ld_b    = 1'b1;
                ctl.sel_min = 1'b1;
                ctl.sel_sub = 1'b1;
                ctl.sel_src = 1'b1;
            end
            ST_COPY: begin
                // A is zero: B - A = B written into A
                ctl.ld_a    = 1'b1;
                ctl.sel_min = 1'b1;
                ctl.sel_sub = 1'b1;
                ctl.sel_src = 1'b1;
            end
            ST_DONE: ctl.done = 1'b1;
            default: ctl = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state = ctrl_q.st;

endmodule

// File: rtl/gcd_core.sv
module gcd_core
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result,
    output logic         done
);

    gcd_ctl_t   ctl;
    gcd_sts_t   sts;
    gcd_state_t state;
    logic [W-1:0] a_val;

    gcd_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .sts   (sts),
        .ctl   (ctl),
        .state (state)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .ctl   (ctl),
        .sts   (sts),
        .a_val (a_val)
    );

    assign result = a_val;
    assign done   = ctl.done;

endmodule

// File: rtl/gcd_core_chk.sv
module gcd_core_chk
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [W-1:0] result,
    input gcd_ctl_t     ctl,
    input gcd_sts_t     sts
);

    // R7: finished state and its value persist without a start
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));

    // R3: subtract into A only when A exceeds B (or the zero-A copy)
    assert_sub_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_a && ctl.sel_src) |-> (sts.gt || sts.a_zero));

    // R3: subtract into B only when B exceeds A
    assert_sub_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_b && ctl.sel_src) |-> sts.lt);

    // R3: a step writes one register; both written only by an external load
    assert_one_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_a && ctl.ld_b) |-> !ctl.sel_src);

    // R3: a true subtraction strictly decreases A
    assert_decrease_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_a && ctl.sel_src && !sts.a_zero) |=> (result < $past(result)));

    // R4: completion only with equal values or a zero second value
    assert_done_eq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sts.eq || sts.b_zero));

    // R7: no register writes while finished
    assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ctl.ld_a && !ctl.ld_b));

endmodule

bind gcd_core gcd_core_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .ctl    (ctl),
    .sts    (sts)
);

// File: tb/gcd_core_tb.sv
module gcd_core_tb;

    localparam int W      = 16;
    localparam int NVEC   = 12;
    localparam int MAXLAT = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    gcd_core #(.W(W)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .done   (done)
    );

    // {a, b}
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {16'd65,    16'd13},
        {16'd13,    16'd65},
        {16'd48,    16'd18},
        {16'd17,    16'd5},
        {16'd100,   16'd100},
        {16'd1,     16'd1},
        {16'd0,     16'd9},
        {16'd9,     16'd0},
        {16'd0,     16'd0},
        {16'd1000,  16'd1},
        {16'd65535, 16'd65535},
        {16'd4096,  16'd1024}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent model: value and edge count from start to done
    task automatic model(input int a, input int b, output int g, output int lat);
        int x = a;
        int y = b;
        int n = 0;
        bit copy = 1'b0;
        while (!(x == y || y == 0 || x == 0)) begin
            if (x > y) x = x - y;
            else       y = y - x;
            n++;
        end
        if (x == y || y == 0) g = x;
        else begin g = y; copy = 1'b1; end
        lat = 3 + 2 * n + (copy ? 1 : 0);
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit inject, output int lat, output int res,
                       output bit low_after_first);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        lat   = 0;
        low_after_first = 1'b0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) begin
                start = 1'b0;
                low_after_first = !done;
            end
            if (inject && lat == 3) begin
                start = 1'b1;
                op_a  = 16'd7;
                op_b  = 16'd3;
            end
            if (inject && lat == 4) start = 1'b0;
            if (done || lat > MAXLAT) break;
        end
        res = result;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, res, g, elat;
        bit low1;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 during reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 idle done", int'(done), 0);
        check(result == '0, "R1 idle result", int'(result), 0);

        // Vector table: R2, R4, R5, R6, R9
        for (int i = 0; i < NVEC; i++) begin
            logic [W-1:0] va, vb;
            va = VEC[i][2*W-1:W];
            vb = VEC[i][W-1:0];
            model(int'(va), int'(vb), g, elat);
            run(va, vb, 1'b0, lat, res, low1);
            check(low1, "R2 done low after load edge", 1, 0);
            check(res == g, "R4 result value", res, g);
            check(lat == elat, "R4 latency", lat, elat);
        end

        // R5: equal all-ones operands, explicit
        run(16'hFFFF, 16'hFFFF, 1'b0, lat, res, low1);
        check(lat == 3 && res == 65535, "R5 equal max width R9", res, 65535);

        // R6: zero corner cases
        run(16'd0, 16'd21, 1'b0, lat, res, low1);
        check(lat == 4 && res == 21, "R6 A zero", lat * 100000 + res, 4 * 100000 + 21);
        run(16'd21, 16'd0, 1'b0, lat, res, low1);
        check(lat == 3 && res == 21, "R6 B zero", lat * 100000 + res, 3 * 100000 + 21);
        run(16'd0, 16'd0, 1'b0, lat, res, low1);
        check(lat == 3 && res == 0, "R6 both zero", lat * 100000 + res, 3 * 100000);

        // R7: hold after done while inputs change without start
        run(16'd65, 16'd13, 1'b0, lat, res, low1);
        @(negedge clk);
        op_a = 16'd99;
        op_b = 16'd33;
        repeat (6) @(negedge clk);
        check(done == 1'b1, "R7 done held", int'(done), 1);
        check(result == 16'd13, "R7 result held", int'(result), 13);

        // R8: start pulse injected mid-run is ignored
        model(48, 18, g, elat);
        run(16'd48, 16'd18, 1'b1, lat, res, low1);
        check(res == g, "R8 busy start value", res, g);
        check(lat == elat, "R8 busy start latency", lat, elat);
        repeat (4) @(negedge clk);
        check(done == 1'b1 && result == 16'(g), "R8 no restart after run", int'(result), g);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule